// File: doc/BRIEF.md
# Timed Transmit Packet Release Gate

This block sits in front of a transmit sample sink and decides when each incoming sample packet may leave. Packets arrive as a valid/ready stream of data beats with a parsed 128-bit packet header on a sideband. The header may carry a 64-bit timestamp. The gate compares that timestamp with a free-running 64-bit tick counter, which runs in the same clock domain as the gate and counts full-rate ticks.

Each packet takes one of three paths. A packet without a timestamp goes straight through. A timestamped packet is held until the counter reaches its stamp and is then released. A timestamped packet whose stamp has already passed is consumed and discarded whole, up to its last beat. Each discard raises a one-cycle late event and increments a saturating late counter. The data path adds no register stage. The gate decides once per packet, at its first beat, and the remaining beats then stream through without another check.

Top module: `tx_time_gate`

## Requirements
- R1: While reset is held and directly after it, `m_tvalid` is 0, `late_pulse` is 0 and `late_count` is 0.
- R2: The header is read only at the first beat of a packet. Bit 125 of `s_tuser` is the time flag (1 = timed) and bits 63:0 are the timestamp. Bits 127:126 hold the packet type, bit 124 the end-of-burst flag, bits 123:112 the sequence number, bits 111:96 the length and bits 95:64 the stream id; the gate does not act on any of these.
- R3: An untimed first beat appears on the output in the same cycle it is presented (`m_tvalid` = 1 in that cycle).
- R4: A timed packet whose stamp is greater than `now_time` is held with `s_tready` = 0 and `m_tvalid` = 0. Its first beat is transferred in the cycle where `now_time` equals the stamp, or at the first ready cycle after that if the output is stalled.
- R5: A timed packet whose stamp equals `now_time` when its first beat is presented is released in that same cycle.
- R6: A timed packet whose stamp is below `now_time` at its first beat is consumed (`s_tready` = 1) and dropped through its `s_tlast` beat. None of its beats reaches the output.
- R7: Each dropped packet raises `late_pulse` for exactly one cycle, the cycle in which its first beat is consumed.
- R8: `late_count` increments by one for each dropped packet and holds at 2^LATE_W-1. It updates on the clock edge that consumes the first beat of the dropped packet.
- R9: After the first beat has passed, the remaining beats of the packet stream without any time check. The headers presented with those beats are ignored.
- R10: When the output stalls (`m_tready` = 0) during a release, `s_tready` is 0. No beat is lost or duplicated, and beats stay in order.
- R11: After any `s_tlast`, including that of a packet with end-of-burst set, the gate evaluates the next packet's header afresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, shared with the tick counter |
| rst_n | input | 1 | Active-low synchronous reset |
| now_time | input | 64 | Current tick counter value |
| s_tdata | input | DATA_W | Input sample beat |
| s_tuser | input | 128 | Parsed packet header, valid at the first beat |
| s_tlast | input | 1 | Last beat of the input packet |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| m_tdata | output | DATA_W | Output sample beat |
| m_tlast | output | 1 | Last beat of the output packet |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Sink accepts output beat |
| late_pulse | output | 1 | One-cycle event per dropped late packet |
| late_count | output | LATE_W | Saturating count of dropped packets |

## Verification
A wrong packet state shows at the ports within the packet it affects:
- A gate stuck in the drop state swallows beats that the scoreboard expects, and the check fails at the next expected output beat.
- A gate wrongly in the pass state emits a beat the queue does not hold.
- A gate that returns to header evaluation in mid-packet drops or holds the rest of that packet, because the later beats carry late stamps.

A mistake in the time compare moves the first beat's release off the stamp cycle, and the release-time check catches it on that beat. A fault in the late counter shows on `late_count` in the first cycle after the dropping edge, and also in the final count once it saturates.

// File: rtl/tgate_pkg.sv
package tgate_pkg;

  typedef struct packed {
    logic [1:0]  kind;
    logic        timed;
    logic        burst_end;
    logic [11:0] seq;
    logic [15:0] len;
    logic [31:0] stream;
    logic [63:0] stamp;
  } pkt_hdr_t;

  typedef enum logic [1:0] {
    ST_HEAD,
    ST_WAIT,
    ST_BODY,
    ST_DROP
  } gate_st_e;

  // Stamp has been reached (release allowed).
  function automatic logic is_due(input logic [63:0] now, input logic [63:0] stamp);
    return now >= stamp;
  endfunction

  // Stamp lies strictly in the past.
  function automatic logic is_late(input logic [63:0] now, input logic [63:0] stamp);
    return now > stamp;
  endfunction

endpackage

// File: rtl/tgate_hdr_unpack.sv
module tgate_hdr_unpack
  import tgate_pkg::*;
(
  input  logic [127:0] raw_hdr,
  output logic         hdr_timed,
  output logic [63:0]  hdr_stamp
);
  pkt_hdr_t hdr;
  logic     unused_hdr_bits;

  assign hdr             = pkt_hdr_t'(raw_hdr);
  assign hdr_timed       = hdr.timed;
  assign hdr_stamp       = hdr.stamp;
  assign unused_hdr_bits = ^{hdr.kind, hdr.burst_end, hdr.seq, hdr.len, hdr.stream};
endmodule

// File: rtl/tgate_late_ctr.sv
module tgate_late_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)                         count <= '0;
    else if (bump && count != CNT_MAX)  count <= count + 1'b1;
  end

  // R8: one step per drop, stops at the top value
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    bump |=> (count == $past(count) + 1'b1) || ($past(count) == CNT_MAX));

  // R8: no drop, no change
  a_r8_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bump |=> $stable(count));
endmodule

// File: rtl/tx_time_gate.sv
module tx_time_gate
  import tgate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       now_time,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic [127:0]      s_tuser,
  input  logic              s_tlast,
  input  logic              s_tvalid,
  output logic              s_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tlast,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              late_pulse,
  output logic [LATE_W-1:0] late_count
);
  gate_st_e    st, st_nxt;
  logic        hdr_timed;
  logic [63:0] hdr_stamp;
  logic        stamp_due, stamp_late, stamp_hit;
  logic        late_drop;      // first beat of a late packet consumed
  logic        release_first;  // first beat offered to the output

  tgate_hdr_unpack u_unpack (
    .raw_hdr   (s_tuser),
    .hdr_timed (hdr_timed),
    .hdr_stamp (hdr_stamp)
  );

  assign stamp_due  = is_due(now_time, hdr_stamp);
  assign stamp_late = is_late(now_time, hdr_stamp);
  assign stamp_hit  = stamp_due && !stamp_late;

  assign m_tdata = s_tdata;
  assign m_tlast = s_tlast;

  always_comb begin
    st_nxt    = st;
    m_tvalid  = 1'b0;
    s_tready  = 1'b0;
    late_drop = 1'b0;
    unique case (st)
      ST_HEAD: begin
        if (s_tvalid) begin
          if (!hdr_timed || stamp_hit) begin
            m_tvalid = 1'b1;
            s_tready = m_tready;
            if (m_tready)       st_nxt = s_tlast ? ST_HEAD : ST_BODY;
            else if (hdr_timed) st_nxt = ST_WAIT;   // release committed
          end else if (stamp_late) begin
            s_tready  = 1'b1;
            late_drop = 1'b1;
            st_nxt    = s_tlast ? ST_HEAD : ST_DROP;
          end else begin
            st_nxt = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (s_tvalid && stamp_due) begin
          m_tvalid = 1'b1;
          s_tready = m_tready;
          if (m_tready) st_nxt = s_tlast ? ST_HEAD : ST_BODY;
        end
      end
      ST_BODY: begin
        m_tvalid = s_tvalid;
        s_tready = m_tready;
        if (s_tvalid && m_tready && s_tlast) st_nxt = ST_HEAD;
      end
      ST_DROP: begin
        s_tready = 1'b1;
        if (s_tvalid && s_tlast) st_nxt = ST_HEAD;
      end
      default: st_nxt = ST_HEAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_HEAD;
    else        st <= st_nxt;
  end

  assign release_first = m_tvalid && (st == ST_HEAD || st == ST_WAIT);
  assign late_pulse    = late_drop;

  tgate_late_ctr #(.CNT_W(LATE_W)) u_late (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (late_drop),
    .count (late_count)
  );

  // R4: a timed first beat never leaves before its stamp
  a_r4_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    (release_first && hdr_timed) |-> (now_time >= hdr_stamp));

  // R4: a held packet blocks both sides
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && now_time < hdr_stamp) |-> (!s_tready && !m_tvalid));

  // R3: untimed first beat is offered at once
  a_r3_untimed_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HEAD && s_tvalid && !hdr_timed) |-> m_tvalid);

  // R6: dropped packets produce nothing at the output
  a_r6_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DROP || late_pulse) |-> !m_tvalid);

  // R7: late event consumes the beat
  a_r7_pulse_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    late_pulse |-> s_tready);

  // R10: output stall stalls the input
  a_r10_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |-> !s_tready);
endmodule

// File: tb/sim_tx_time_gate.sv
module sim_tx_time_gate;
  localparam int DW = 32;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [63:0]   now_time;
  logic [DW-1:0] s_tdata;
  logic [127:0]  s_tuser;
  logic          s_tlast, s_tvalid, s_tready;
  logic [DW-1:0] m_tdata;
  logic          m_tlast, m_tvalid;
  logic          m_tready = 1'b1;
  logic          late_pulse;
  logic [LW-1:0] late_count;

  always #10 clk = ~clk;   // 50 MHz

  tx_time_gate #(.DATA_W(DW), .LATE_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .now_time(now_time),
    .s_tdata(s_tdata), .s_tuser(s_tuser), .s_tlast(s_tlast),
    .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tlast(m_tlast), .m_tvalid(m_tvalid),
    .m_tready(m_tready), .late_pulse(late_pulse), .late_count(late_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) now_time <= 64'd0;
    else        now_time <= now_time + 64'd1;
  end

  typedef struct {
    logic [DW-1:0] data;
    logic          last;
    bit            first;
    bit            timed;
    bit            exact;
    logic [63:0]   stamp;
    string         req;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  int   tests = 0, fails = 0, lp_seen = 0;
  bit   throttle = 1'b0, finished = 1'b0;
  logic [7:0] lfsr = 8'h5a;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // R2 layout: [127:126] type, [125] timed, [124] eob, [123:112] seq,
  // [111:96] length, [95:64] stream id, [63:0] stamp
  function automatic logic [127:0] mkhdr(input bit timed, input bit eob,
                                         input logic [63:0] st, input logic [11:0] seq);
    return {2'b01, timed, eob, seq, 16'd64, 32'hC0DE_0001, st};
  endfunction

  // Ready pattern for the sink
  always begin
    @(posedge clk); #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    m_tready = throttle ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (late_pulse) lp_seen++;
      if (m_tvalid && m_tready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "unexpected output beat", m_tdata, 0);
        end else begin
          cur = exp_q.pop_front();
          chk(m_tdata == cur.data, cur.req, "beat data", m_tdata, cur.data);
          chk(m_tlast == cur.last, cur.req, "beat last", m_tlast, cur.last);
          if (cur.first && cur.timed) begin
            if (cur.exact) chk(now_time == cur.stamp, cur.req, "release time", now_time, cur.stamp);
            else           chk(now_time >= cur.stamp, cur.req, "release not early", now_time, cur.stamp);
          end
        end
      end
    end
  end

  task automatic send_pkt(input bit timed, input bit eob, input logic [63:0] stamp,
                          input int beats, input logic [DW-1:0] base,
                          input bit drop, input string req);
    bit hold_checked = 1'b0;
    bit first_look;
    bit hs;
    if (!drop)
      for (int b = 0; b < beats; b++)
        exp_q.push_back('{base + DW'(b), b == beats - 1, b == 0, timed, !throttle, stamp, req});
    for (int b = 0; b < beats; b++) begin
      s_tdata    = base + DW'(b);
      s_tlast    = (b == beats - 1);
      // R9: later beats carry a late timed header that must be ignored
      s_tuser    = (b == 0) ? mkhdr(timed, eob, stamp, 12'(b)) : mkhdr(1'b1, 1'b0, 64'd0, 12'(b));
      s_tvalid   = 1'b1;
      first_look = 1'b1;
      forever begin
        @(negedge clk);
        if (b == 0 && timed && !drop && now_time < stamp && !hold_checked) begin
          hold_checked = 1'b1;
          chk(!s_tready && !m_tvalid, "R4", "held while early", {s_tready, m_tvalid}, 0);
        end
        if (b == 0 && first_look && drop)
          chk(late_pulse == 1'b1, "R7", "late pulse on drop", late_pulse, 1);
        if (b == 0 && first_look && !timed && !throttle)
          chk(m_tvalid == 1'b1, "R3", "untimed passes at once", m_tvalid, 1);
        if (b == 0 && first_look && timed && !drop && stamp == now_time && !throttle)
          chk(m_tvalid == 1'b1, "R5", "on-time passes at once", m_tvalid, 1);
        first_look = 1'b0;
        hs = s_tvalid && s_tready;
        @(posedge clk); #2;
        if (hs) break;
      end
    end
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(posedge clk);
    #2;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; s_tvalid = 1'b0; s_tlast = 1'b0; s_tdata = '0; s_tuser = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(m_tvalid == 1'b0, "R1", "m_tvalid in reset", m_tvalid, 0);
    chk(late_pulse == 1'b0, "R1", "late_pulse in reset", late_pulse, 0);
    chk(late_count == '0, "R1", "late_count in reset", late_count, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (10) @(posedge clk);
    #2;
    chk(m_tvalid == 1'b0 && late_count == '0, "R1", "idle after reset", {m_tvalid, late_count}, 0);

    // R3: untimed, immediate
    send_pkt(1'b0, 1'b0, 64'd0, 4, 32'h100, 1'b0, "R3");
    // R4 / R9 / R2: timed in the future
    send_pkt(1'b1, 1'b0, now_time + 64'd15, 3, 32'h200, 1'b0, "R4");
    drain();
    // R6 / R7: late packet dropped whole
    send_pkt(1'b1, 1'b0, now_time - 64'd5, 3, 32'h300, 1'b1, "R6");
    chk(late_count == 3'd1, "R8", "count after one drop", late_count, 1);
    // R5: stamp equals now
    send_pkt(1'b1, 1'b0, now_time, 2, 32'h400, 1'b0, "R5");
    drain();
    chk(exp_q.size() == 0, "R6", "no beat of dropped packet", exp_q.size(), 0);

    // R10: throttled sink, mixed traffic
    throttle = 1'b1;
    send_pkt(1'b0, 1'b0, 64'd0, 5, 32'h500, 1'b0, "R10");
    send_pkt(1'b1, 1'b0, now_time + 64'd8, 4, 32'h600, 1'b0, "R10");
    send_pkt(1'b0, 1'b1, 64'd0, 3, 32'h700, 1'b0, "R11");
    // R11: after an end-of-burst packet, next header evaluated afresh
    send_pkt(1'b1, 1'b0, now_time - 64'd3, 1, 32'h800, 1'b1, "R11");
    send_pkt(1'b1, 1'b0, now_time + 64'd6, 2, 32'h900, 1'b0, "R11");
    drain();
    throttle = 1'b0;
    repeat (2) @(posedge clk);
    #2;

    // R8: saturation
    for (int k = 0; k < 7; k++)
      send_pkt(1'b1, 1'b0, now_time - 64'd1, 1, 32'hA00 + DW'(k), 1'b1, "R8");
    chk(late_count == 3'd7, "R8", "count saturates", late_count, 7);
    // R6 with a multi-beat drop after saturation
    send_pkt(1'b1, 1'b0, now_time - 64'd2, 2, 32'hB00, 1'b1, "R6");
    chk(late_count == 3'd7, "R8", "count holds at max", late_count, 7);
    send_pkt(1'b0, 1'b0, 64'd0, 2, 32'hC00, 1'b0, "R9");
    drain();
    repeat (3) @(negedge clk);

    chk(exp_q.size() == 0, "R10", "all expected beats seen", exp_q.size(), 0);
    chk(lp_seen == 10, "R7", "late pulses total", lp_seen, 10);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule